// File: doc/BRIEF.md
# Gate Drive Sequencer with Fault Overrides

This block is the per-phase switching core of a multiphase buck converter. A registered PWM latch is set by a clock-slot pulse and cleared by a ramp-crossing pulse. When both arrive in the same cycle, the clear wins. Two latched interlocks turn the latch state into a high-side and a low-side gate enable.

The high side turns on only after a digitised "low gate below 1 V" flag has been seen. The low side turns on only after a "switch node below 1 V" flag has been seen. Each interlock holds its decision once made, so a noisy comparator flag cannot retrigger it.

Fault and mode flags sit on top of normal PWM in a fixed priority:

1. Debug pulls both gates low.
2. Over-voltage forces the low side on and the high side off.
3. A power-state request parks both gates.
4. Body braking and a negative-current condition hold the low side off.

The negative-current condition is "output below three quarters of the reference while current flows backwards". It is latched until the next clock-slot set pulse. A tri-state flag reports when an override holds the phase with both gates off.

Top module: `gate_sequencer`

## Requirements
- R1: When `slot_set` and `ramp_cross` are high in the same cycle, the PWM latch ends up cleared. `hs_en` is low in the following cycle, and a low side that was already on stays on.
- R2: A `slot_set` pulse drops `ls_en` in the cycle after the edge that samples it. `hs_en` rises only one cycle after an edge that samples `lo_below` high while the latch is set.
- R3: A `ramp_cross` pulse drops `hs_en` in the cycle after the edge that samples it. `ls_en` rises only one cycle after an edge that samples `sw_below` high while the latch is cleared.
- R4: Once a gate is enabled by its interlock, it stays enabled while the latch keeps its state, even if the flag that allowed it (`lo_below` or `sw_below`) returns low.
- R5: While `brake` is high, `ls_en` is low and `hs_en` follows normal PWM. `tri_state` is high exactly when the high side is also off.
- R6: While `ovp` is high and `debug` is low, `hs_en` is 0 and `ls_en` is 1. This holds whatever the states of `brake`, `pwr_off` and the PWM latch. When `ovp` clears, normal drive resumes at once.
- R7: `out_low` and `neg_cur` both high force `ls_en` low and set a hold. The hold survives `ramp_cross` pulses and is cleared only by the next `slot_set` pulse. `out_low` alone has no effect.
- R8: While `debug` is high, `hs_en` and `ls_en` are both 0 and `tri_state` is 1, including when `ovp` is also high.
- R9: While `pwr_off` is high and neither `debug` nor `ovp` is high, both gates are off and `tri_state` is 1.
- R10: With `ramp_cross` held low, `hs_en` stays on across repeated `slot_set` pulses (100% duty). The latch is set only by a `slot_set` pulse.
- R11: During and right after reset, `hs_en`, `ls_en` and `tri_state` are 0, and the PWM latch is cleared.
- R12: `hs_en` and `ls_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_set | input | 1 | Clock-slot set pulse for the PWM latch |
| ramp_cross | input | 1 | Ramp-crossing clear for the PWM latch |
| lo_below | input | 1 | Low-side gate below 1 V |
| sw_below | input | 1 | Switch node below 1 V |
| brake | input | 1 | Body-brake comparator flag |
| ovp | input | 1 | Over-voltage flag |
| debug | input | 1 | Debug isolation flag |
| pwr_off | input | 1 | Power-state off request |
| out_low | input | 1 | Output below 75% of reference |
| neg_cur | input | 1 | Negative inductor current detected |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| tri_state | output | 1 | Both gates held off by an override |

## Verification
The collisions that matter are these:

- A set pulse and a ramp crossing landing on the same edge.
- Several override flags raised together.

The bench drives `slot_set` and `ramp_cross` high in one cycle, once from a conducting low side and once from a conducting high side. It then judges that the high side is off and the low side is unchanged.

It raises `ovp` together with `brake` and `pwr_off`, and `debug` together with `ovp`. In each case it checks that only the highest-priority override shapes the outputs.

The negative-current hold is raised and then crossed with a ramp clear, to show that only a set pulse releases it.

// File: rtl/gs_pkg.sv
package gs_pkg;
   typedef struct packed {
      logic hs;
      logic ls;
   } gate_t;

   typedef enum logic [2:0] {
      OVR_NONE   = 3'd0,
      OVR_LSOFF  = 3'd1,
      OVR_PARK   = 3'd2,
      OVR_OVP    = 3'd3,
      OVR_DEBUG  = 3'd4
   } ovr_e;
endpackage

// File: rtl/gs_pwm_latch.sv
module gs_pwm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= 1'b0;
      else if (clr_i)  q_r <= 1'b0;
      else if (set_i)  q_r <= 1'b1;
   end

   assign q_o = q_r;

   // R1
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q_o);

   // R10
   set_only_by_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_o) |-> $past(set_i));
endmodule

// File: rtl/gs_nonoverlap.sv
module gs_nonoverlap
   import gs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pwm_i,
   input  logic  lo_below_i,
   input  logic  sw_below_i,
   output gate_t gate_o
);
   logic hs_arm, ls_arm;

   // Each arm latches its permission and is dropped only by the opposite latch state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_arm <= 1'b0;
         ls_arm <= 1'b0;
      end else begin
         hs_arm <= pwm_i  & (hs_arm | lo_below_i);
         ls_arm <= !pwm_i & (ls_arm | sw_below_i);
      end
   end

   // Qualify with the live latch state so a flip removes the old gate at once.
   assign gate_o.hs = hs_arm & pwm_i;
   assign gate_o.ls = ls_arm & !pwm_i;

   // R2
   hs_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_arm) |-> $past(lo_below_i));

   // R3
   ls_after_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_arm) |-> $past(sw_below_i));

   // R4
   hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hs_arm) && $past(pwm_i) && pwm_i) |-> gate_o.hs);
endmodule

// File: rtl/gs_neg_hold.sv
module gs_neg_hold #(
   parameter int unsigned LATCHED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic low_i,
   input  logic neg_i,
   output logic hold_o
);
   logic cond;
   assign cond = low_i & neg_i;

   generate
      if (LATCHED > 1) begin : g_bad
         $error("gs_neg_hold: LATCHED must be 0 or 1");
      end

      if (LATCHED == 1) begin : g_latched
         logic held;

         // The condition dominates; the next set pulse releases the hold.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      held <= 1'b0;
            else if (cond)   held <= 1'b1;
            else if (set_i)  held <= 1'b0;
         end

         assign hold_o = held | cond;

         // R7
         neg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (held && !set_i) |=> hold_o);
      end else begin : g_direct
         assign hold_o = cond;
      end
   endgenerate
endmodule

// File: rtl/gs_override.sv
module gs_override
   import gs_pkg::*;
(
   input  gate_t pwm_gate_i,
   input  logic  debug_i,
   input  logic  ovp_i,
   input  logic  park_i,
   input  logic  lsoff_i,
   output gate_t gate_o,
   output logic  tri_o
);
   ovr_e sel;

   always_comb begin
      if (debug_i)      sel = OVR_DEBUG;
      else if (ovp_i)   sel = OVR_OVP;
      else if (park_i)  sel = OVR_PARK;
      else if (lsoff_i) sel = OVR_LSOFF;
      else              sel = OVR_NONE;
   end

   always_comb begin
      gate_o = pwm_gate_i;
      tri_o  = 1'b0;
      unique case (sel)
         OVR_DEBUG, OVR_PARK: begin
            gate_o = '0;
            tri_o  = 1'b1;
         end
         OVR_OVP: begin
            gate_o.hs = 1'b0;
            gate_o.ls = 1'b1;
         end
         OVR_LSOFF: begin
            gate_o.ls = 1'b0;
            tri_o     = !pwm_gate_i.hs;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
   parameter int unsigned NEG_LATCHED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_set,
   input  logic ramp_cross,
   input  logic lo_below,
   input  logic sw_below,
   input  logic brake,
   input  logic ovp,
   input  logic debug,
   input  logic pwr_off,
   input  logic out_low,
   input  logic neg_cur,
   output logic hs_en,
   output logic ls_en,
   output logic tri_state
);
   import gs_pkg::*;

   logic  pwm_q;
   logic  neg_hold;
   gate_t pwm_gate;
   gate_t out_gate;

   gs_pwm_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (slot_set),
      .clr_i (ramp_cross),
      .q_o   (pwm_q)
   );

   gs_nonoverlap u_nov (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm_i      (pwm_q),
      .lo_below_i (lo_below),
      .sw_below_i (sw_below),
      .gate_o     (pwm_gate)
   );

   gs_neg_hold #(.LATCHED(NEG_LATCHED)) u_neg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (slot_set),
      .low_i  (out_low),
      .neg_i  (neg_cur),
      .hold_o (neg_hold)
   );

   gs_override u_ovr (
      .pwm_gate_i (pwm_gate),
      .debug_i    (debug),
      .ovp_i      (ovp),
      .park_i     (pwr_off),
      .lsoff_i    (brake | neg_hold),
      .gate_o     (out_gate),
      .tri_o      (tri_state)
   );

   assign hs_en = out_gate.hs;
   assign ls_en = out_gate.ls;

   // R12
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   // R6
   ovp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovp && !debug) |-> (ls_en && !hs_en));

   // R8
   debug_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debug |-> (!hs_en && !ls_en && tri_state));

   // R5
   brake_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brake && !ovp) |-> !ls_en);

   // R1
   clear_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_cross |=> !hs_en);
endmodule

// File: tb/sim_gate_sequencer.sv
module sim_gate_sequencer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slot_set = 0, ramp_cross = 0, lo_below = 0, sw_below = 0;
   logic brake = 0, ovp = 0, debug = 0, pwr_off = 0, out_low = 0, neg_cur = 0;
   logic hs_en, ls_en, tri_state;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   always #5 clk = ~clk;

   gate_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .slot_set(slot_set), .ramp_cross(ramp_cross),
      .lo_below(lo_below), .sw_below(sw_below), .brake(brake), .ovp(ovp),
      .debug(debug), .pwr_off(pwr_off), .out_low(out_low), .neg_cur(neg_cur),
      .hs_en(hs_en), .ls_en(ls_en), .tri_state(tri_state)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go_ls_on();
      ramp_cross = 1; sw_below = 1; lo_below = 0;
      cyc(1);
      ramp_cross = 0;
      cyc(1);
   endtask

   task automatic go_hs_on();
      slot_set = 1; sw_below = 0;
      cyc(1);
      slot_set = 0; lo_below = 1;
      cyc(1);
   endtask

   task automatic t_reset();
      chk("R11", "hs in reset", hs_en, 0);
      chk("R11", "ls in reset", ls_en, 0);
      rst_n = 1;
      cyc(1);
      chk("R11", "hs after reset", hs_en, 0);
      chk("R11", "ls after reset", ls_en, 0);
      chk("R11", "tri after reset", tri_state, 0);
   endtask

   task automatic t_set_path();
      go_ls_on();
      lo_below = 0;
      slot_set = 1;
      cyc(1);
      slot_set = 0;
      chk("R2", "ls off after set", ls_en, 0);
      chk("R2", "hs waits", hs_en, 0);
      cyc(1);
      chk("R2", "hs still waits", hs_en, 0);
      lo_below = 1;
      cyc(1);
      chk("R2", "hs on after lo_below", hs_en, 1);
      lo_below = 0;
      cyc(2);
      chk("R4", "hs held despite noise", hs_en, 1);
   endtask

   task automatic t_clear_path();
      go_hs_on();
      sw_below = 0;
      ramp_cross = 1;
      cyc(1);
      ramp_cross = 0;
      chk("R3", "hs off after clear", hs_en, 0);
      chk("R3", "ls waits", ls_en, 0);
      cyc(1);
      chk("R3", "ls still waits", ls_en, 0);
      sw_below = 1;
      cyc(1);
      chk("R3", "ls on after sw_below", ls_en, 1);
      sw_below = 0;
      cyc(2);
      chk("R4", "ls held despite noise", ls_en, 1);
   endtask

   task automatic t_collide();
      go_ls_on();
      slot_set = 1; ramp_cross = 1;
      cyc(1);
      slot_set = 0; ramp_cross = 0;
      chk("R1", "hs off on collision from ls", hs_en, 0);
      chk("R1", "ls kept on collision", ls_en, 1);
      go_hs_on();
      slot_set = 1; ramp_cross = 1;
      cyc(1);
      slot_set = 0; ramp_cross = 0;
      chk("R1", "hs off on collision from hs", hs_en, 0);
   endtask

   task automatic t_full_duty();
      go_hs_on();
      for (int i = 0; i < 3; i++) begin
         slot_set = 1;
         cyc(1);
         slot_set = 0;
         cyc(1);
         chk("R10", "hs stays at full duty", hs_en, 1);
      end
      ramp_cross = 1;
      cyc(1);
      ramp_cross = 0;
      cyc(3);
      chk("R10", "no turn-on without slot", hs_en, 0);
   endtask

   task automatic t_brake();
      go_ls_on();
      brake = 1;
      cyc(1);
      chk("R5", "ls off in brake", ls_en, 0);
      chk("R5", "tri in brake", tri_state, 1);
      brake = 0;
      cyc(1);
      chk("R5", "ls back after brake", ls_en, 1);
      go_hs_on();
      brake = 1;
      cyc(1);
      chk("R5", "hs unaffected by brake", hs_en, 1);
      chk("R5", "no tri with hs on", tri_state, 0);
      brake = 0;
   endtask

   task automatic t_ovp();
      go_hs_on();
      ovp = 1; brake = 1; pwr_off = 1;
      cyc(1);
      chk("R6", "hs off in ovp", hs_en, 0);
      chk("R6", "ls forced on in ovp", ls_en, 1);
      chk("R6", "no tri in ovp", tri_state, 0);
      ovp = 0; brake = 0; pwr_off = 0;
      cyc(1);
      chk("R6", "hs resumes after ovp", hs_en, 1);
   endtask

   task automatic t_debug();
      go_ls_on();
      debug = 1; ovp = 1;
      cyc(1);
      chk("R8", "hs off in debug", hs_en, 0);
      chk("R8", "ls off in debug over ovp", ls_en, 0);
      chk("R8", "tri in debug", tri_state, 1);
      debug = 0; ovp = 0;
   endtask

   task automatic t_park();
      go_ls_on();
      pwr_off = 1; brake = 1;
      cyc(1);
      chk("R9", "ls off in park", ls_en, 0);
      chk("R9", "tri in park", tri_state, 1);
      pwr_off = 0; brake = 0;
      cyc(1);
      chk("R9", "ls back after park", ls_en, 1);
   endtask

   task automatic t_negative();
      go_ls_on();
      out_low = 1;
      cyc(1);
      chk("R7", "out_low alone no effect", ls_en, 1);
      neg_cur = 1;
      cyc(1);
      chk("R7", "ls off on negative current", ls_en, 0);
      out_low = 0; neg_cur = 0;
      cyc(3);
      chk("R7", "hold persists", ls_en, 0);
      go_ls_on();
      chk("R7", "hold survives ramp clear", ls_en, 0);
      slot_set = 1;
      cyc(1);
      slot_set = 0;
      go_ls_on();
      chk("R7", "set pulse releases hold", ls_en, 1);
   endtask

   initial begin
      cyc(3);
      t_reset();
      t_set_path();
      t_clear_path();
      t_collide();
      t_full_duty();
      t_brake();
      t_ovp();
      t_debug();
      t_park();
      t_negative();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule